// File: doc/BRIEF.md
# OTP Wiper Register with Two-Wire Target

This block is the digital side of a 64-step trimming potentiometer. It holds a 6-bit wiper code and serves it over a two-wire (I2C) bus as a target. The setting can be rewritten as often as needed during calibration. A single burn command then freezes it for good, like epoxy on a mechanical trimmer. A register stands in for the fuse, and a cycle counter stands in for its long programming pulse.

SCL and SDA are sampled by a fast system clock through synchronizers. START and STOP are detected from data-line edges while the clock line is high. A write frame carries an address byte, an operation byte and a data byte. A read returns one byte: two lock-status bits on top and the wiper code below. One address bit comes from a select pin, so two of these blocks can share a bus. While the burn is running, the block stays off the bus.

Top module: `otp_wiper_i2c`

## Requirements
- R1: After reset the wiper code is 0, the lock status is 00 and the block does not pull SDA.
- R2: The block acknowledges only the 7-bit address 0,1,0,1,1,S,0 (MSB first), where S is the select pin. For any other address it does not pull SDA and nothing changes.
- R3: While unlocked, a write frame (address with R/W=0, operation byte, data byte) whose operation bits 7 and 6 are both 0 sets the wiper to data bits 5..0. Data bits 7..6 are ignored, and any number of such writes is allowed.
- R4: A read frame (R/W=1) returns the byte {status[1:0], wiper[5:0]}, MSB first. If the controller acknowledges, the same byte is sent again.
- R5: Operation bit 6 set while unlocked loads the data code into both the wiper and the fuse, then starts a burn that lasts exactly BURN_CYCLES clock cycles. During the burn the block does not acknowledge its address.
- R6: Once the burn has finished, the lock is permanent and writes no longer change the wiper.
- R7: The status reads 00 while unprogrammed, 01 after a clean burn, and 11 if the fault input was high in any cycle of the burn. It never reads 10.
- R8: Operation bit 7 set with bit 6 clear copies the fuse value into the wiper. Before any burn the fuse holds 0.
- R9: A burn command sent after the lock is acknowledged but changes neither the wiper nor the status.
- R10: The block changes its pull on SDA only while SCL is low.
- R11: In a write frame, every byte after the data byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 1 | Supplies address bit 1 |
| burn_fault_i | input | 1 | Fault flag from the fuse programmer, sampled during the burn |
| sda_pull_o | output | 1 | High drives SDA low (open-drain enable) |
| wiper_o | output | 6 | Current wiper code for the resistor ladder |

## Verification
Random frames mix valid writes with random codes (junk in the upper data bits), refresh operations, bus reads and writes to random foreign addresses. This separates data-path errors from address-decode errors and from upper-bit leakage. Directed frames cover the rest. Flipping the select pin tests R2. A repeated read tests R4. A trailing fourth byte tests R11. Two burn runs are made, one clean and one with the fault pulsed. Before the burn ends, the bench probes the address to show the block stays silent. After the lock, the bench sends writes, a second burn and a refresh, and each one must leave the frozen code and the status unchanged.

// File: rtl/otpw_pkg.sv
`timescale 1ns/1ps
package otpw_pkg;
  localparam int WIPER_W = 6;
  localparam logic [4:0] ADDR_FIXED_HI = 5'b01011;

  typedef enum logic [1:0] {
    FUSE_OPEN,
    FUSE_BURN,
    FUSE_GOOD,
    FUSE_BAD
  } fuse_st_e;

  typedef enum logic [2:0] {
    T_IDLE,
    T_RX,
    T_ACK,
    T_TX,
    T_TXACK,
    T_WAIT
  } tgt_st_e;
endpackage

// File: rtl/otpw_line_sync.sv
`timescale 1ns/1ps
module otpw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_chain[LAST];
      sda_q <= sda_chain[LAST];
    end
  end

  assign sda_o      = sda_chain[LAST];
  assign scl_rise_o = scl_chain[LAST] & ~scl_q;
  assign scl_fall_o = ~scl_chain[LAST] & scl_q;
  assign start_o    = scl_chain[LAST] & scl_q & sda_q & ~sda_chain[LAST];
  assign stop_o     = scl_chain[LAST] & scl_q & ~sda_q & sda_chain[LAST];
endmodule

// File: rtl/otpw_i2c_target.sv
`timescale 1ns/1ps
module otpw_i2c_target
  import otpw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               addr_sel_i,
  input  logic               busy_i,
  input  logic [7:0]         rd_byte_i,
  output logic               sda_pull_o,
  output logic               cmd_valid_o,
  output logic [1:0]         cmd_op_o,
  output logic [WIPER_W-1:0] cmd_data_o
);
  tgt_st_e     st;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [1:0]  byte_idx;
  logic        is_read;
  logic        master_ack;
  logic [6:0]  own_addr;

  assign own_addr = {ADDR_FIXED_HI, addr_sel_i, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= T_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      byte_idx    <= '0;
      is_read     <= 1'b0;
      master_ack  <= 1'b0;
      sda_pull_o  <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= '0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (start_i) begin
        st         <= T_RX;
        bitcnt     <= '0;
        byte_idx   <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        st         <= T_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          T_RX: begin
            if (scl_rise_i) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall_i && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (byte_idx)
                2'd0: begin
                  if (shreg[7:1] == own_addr && !busy_i) begin
                    is_read    <= shreg[0];
                    sda_pull_o <= 1'b1;
                    st         <= T_ACK;
                  end else begin
                    st <= T_WAIT;
                  end
                end
                2'd1: begin
                  cmd_op_o   <= shreg[7:6];
                  sda_pull_o <= 1'b1;
                  st         <= T_ACK;
                end
                2'd2: begin
                  cmd_data_o  <= shreg[WIPER_W-1:0];
                  cmd_valid_o <= 1'b1;
                  sda_pull_o  <= 1'b1;
                  st          <= T_ACK;
                end
                default: st <= T_WAIT;
              endcase
            end
          end
          T_ACK: begin
            if (scl_fall_i) begin
              byte_idx <= byte_idx + 2'd1;
              if (is_read) begin
                shreg      <= rd_byte_i;
                sda_pull_o <= ~rd_byte_i[7];
                st         <= T_TX;
              end else begin
                sda_pull_o <= 1'b0;
                st         <= T_RX;
              end
            end
          end
          T_TX: begin
            if (scl_fall_i) begin
              if (bitcnt == 4'd7) begin
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
                st         <= T_TXACK;
              end else begin
                shreg      <= {shreg[6:0], 1'b0};
                sda_pull_o <= ~shreg[6];
                bitcnt     <= bitcnt + 4'd1;
              end
            end
          end
          T_TXACK: begin
            if (scl_rise_i) begin
              master_ack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (master_ack) begin
                shreg      <= rd_byte_i;
                sda_pull_o <= ~rd_byte_i[7];
                st         <= T_TX;
              end else begin
                st <= T_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/otpw_fuse_ctrl.sv
`timescale 1ns/1ps
module otpw_fuse_ctrl
  import otpw_pkg::*;
#(
  parameter int BURN_CYCLES = 20_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [WIPER_W-1:0] cmd_data_i,
  input  logic               fault_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic [1:0]         status_o,
  output logic               busy_o,
  output fuse_st_e           state_o
);
  localparam int CNT_W = $clog2(BURN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURN_CYCLES - 1);

  fuse_st_e           state;
  logic [CNT_W-1:0]   timer;
  logic               fault_seen;
  logic [WIPER_W-1:0] fuse_q;
  logic               op_refresh;
  logic               op_burn;

  assign op_refresh = cmd_op_i[1];
  assign op_burn    = cmd_op_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FUSE_OPEN;
      timer      <= '0;
      fault_seen <= 1'b0;
      fuse_q     <= '0;
      wiper_o    <= '0;
    end else begin
      case (state)
        FUSE_OPEN: begin
          if (cmd_valid_i) begin
            if (op_burn) begin
              wiper_o    <= cmd_data_i;
              fuse_q     <= cmd_data_i;
              timer      <= '0;
              fault_seen <= 1'b0;
              state      <= FUSE_BURN;
            end else if (op_refresh) begin
              wiper_o <= fuse_q;
            end else begin
              wiper_o <= cmd_data_i;
            end
          end
        end
        FUSE_BURN: begin
          if (timer == CNT_LAST) begin
            state <= (fault_seen || fault_i) ? FUSE_BAD : FUSE_GOOD;
          end else begin
            timer      <= timer + 1'b1;
            fault_seen <= fault_seen | fault_i;
          end
        end
        default: begin
          if (cmd_valid_i && op_refresh && !op_burn) begin
            wiper_o <= fuse_q;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (state)
      FUSE_GOOD: status_o = 2'b01;
      FUSE_BAD:  status_o = 2'b11;
      default:   status_o = 2'b00;
    endcase
  end

  assign busy_o  = (state == FUSE_BURN);
  assign state_o = state;
endmodule

// File: rtl/otp_wiper_i2c.sv
`timescale 1ns/1ps
module otp_wiper_i2c
  import otpw_pkg::*;
#(
  parameter int BURN_CYCLES = 20_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_sel_i,
  input  logic               burn_fault_i,
  output logic               sda_pull_o,
  output logic [WIPER_W-1:0] wiper_o
);
  logic               sda_s;
  logic               scl_rise;
  logic               scl_fall;
  logic               bus_start;
  logic               bus_stop;
  logic               cmd_valid;
  logic [1:0]         cmd_op;
  logic [WIPER_W-1:0] cmd_data;
  logic [1:0]         status;
  logic               busy;
  fuse_st_e           fstate;
  logic [7:0]         rd_byte;

  assign rd_byte = {status, wiper_o};

  otpw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  otpw_i2c_target u_tgt (
    .clk(clk), .rst(rst), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop),
    .addr_sel_i(addr_sel_i), .busy_i(busy), .rd_byte_i(rd_byte),
    .sda_pull_o(sda_pull_o), .cmd_valid_o(cmd_valid),
    .cmd_op_o(cmd_op), .cmd_data_o(cmd_data)
  );

  otpw_fuse_ctrl #(.BURN_CYCLES(BURN_CYCLES)) u_fuse (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .fault_i(burn_fault_i),
    .wiper_o(wiper_o), .status_o(status), .busy_o(busy), .state_o(fstate)
  );
endmodule

// File: rtl/otpw_checker.sv
`timescale 1ns/1ps
module otpw_checker
  import otpw_pkg::*;
#(
  parameter int BURN_CYCLES = 20_000_000
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_i,
  input logic               sda_pull_o,
  input logic [WIPER_W-1:0] wiper_o,
  input fuse_st_e           fstate,
  input logic [1:0]         status
);
  int unsigned burn_run;
  logic        locked;

  assign locked = (fstate == FUSE_GOOD) || (fstate == FUSE_BAD);

  always_ff @(posedge clk) begin
    if (rst) burn_run <= 0;
    else if (fstate == FUSE_BURN) burn_run <= burn_run + 1;
    else burn_run <= 0;
  end

  a_r5_burn_bounded: assert property (@(posedge clk) disable iff (rst)
    burn_run <= BURN_CYCLES);

  a_r5_burn_length: assert property (@(posedge clk) disable iff (rst)
    ($past(fstate) == FUSE_BURN && fstate != FUSE_BURN) |-> burn_run == BURN_CYCLES);

  a_r5_silent_in_burn: assert property (@(posedge clk) disable iff (rst)
    (fstate == FUSE_BURN && $past(fstate) == FUSE_BURN) |-> !$rose(sda_pull_o));

  a_r6_lock_permanent: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  a_r6_wiper_frozen: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(wiper_o));

  a_r7_status_legal: assert property (@(posedge clk) disable iff (rst)
    status != 2'b10);

  a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_i);
endmodule

bind otp_wiper_i2c otpw_checker #(.BURN_CYCLES(BURN_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .wiper_o(wiper_o), .fstate(fstate), .status(status)
);

// File: tb/otp_wiper_i2c_test.sv
`timescale 1ns/1ps
module otp_wiper_i2c_test;
  localparam int BURN = 2000;
  localparam int Q    = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sel = 1'b1;
  logic       fault = 1'b0;
  logic       sda_pull;
  logic [5:0] wiper;
  logic       sda_line;

  int total = 0;
  int bad = 0;
  int r10_viol = 0;
  bit done = 0;

  logic [5:0] m_wiper;
  logic [5:0] m_fuse;
  logic [1:0] m_status;
  bit         m_locked;

  assign sda_line = sda_m & ~sda_pull;

  always #2.5 clk = ~clk;

  otp_wiper_i2c #(.BURN_CYCLES(BURN), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(sel), .burn_fault_i(fault),
    .sda_pull_o(sda_pull), .wiper_o(wiper)
  );

  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl_m && sda_pull !== pull_prev) r10_viol++;
    pull_prev <= sda_pull;
  end

  function automatic logic [6:0] own(input logic s);
    return {5'b01011, s, 1'b0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; qw;
    sda_m = 1'b0; qw;
    scl_m = 1'b0; qw;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qw;
    scl_m = 1'b1; qw;
    sda_m = 1'b1; qw;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw;
      scl_m = 1'b1; qw; qw;
      scl_m = 1'b0; qw;
    end
    sda_m = 1'b1; qw;
    scl_m = 1'b1; qw;
    ack = ~sda_line; qw;
    scl_m = 1'b0; qw;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; qw;
      scl_m = 1'b1; qw;
      b[i] = sda_line; qw;
      scl_m = 1'b0; qw;
    end
    sda_m = ~give_ack; qw;
    scl_m = 1'b1; qw; qw;
    scl_m = 1'b0; qw;
    sda_m = 1'b1;
  endtask

  task automatic write_frame(input logic [6:0] a, input logic [7:0] op,
                             input logic [7:0] d, output logic [2:0] acks);
    logic k;
    acks = '0;
    bus_start;
    send_byte({a, 1'b0}, k); acks[2] = k;
    if (k) begin
      send_byte(op, k); acks[1] = k;
      send_byte(d, k);  acks[0] = k;
    end
    bus_stop;
  endtask

  task automatic read_frame(input logic [6:0] a, output logic ack, output logic [7:0] b);
    bus_start;
    send_byte({a, 1'b1}, ack);
    b = 8'h00;
    if (ack) recv_byte(1'b0, b);
    bus_stop;
  endtask

  task automatic model_write(input logic [7:0] op, input logic [7:0] d);
    if (!m_locked) begin
      if (op[6]) begin
        m_wiper = d[5:0]; m_fuse = d[5:0];
      end else if (op[7]) m_wiper = m_fuse;
      else m_wiper = d[5:0];
    end else if (op[7] && !op[6]) begin
      m_wiper = m_fuse;
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    m_wiper = 0; m_fuse = 0; m_status = 0; m_locked = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [2:0] acks;
    logic       ack;
    logic [7:0] rb;
    logic [7:0] rb2;
    logic [7:0] op;
    logic [7:0] d;
    logic [6:0] a;
    void'($urandom(32'd4711));

    do_reset;
    chk("R1 wiper after reset", wiper, 0);
    chk("R1 sda released after reset", sda_pull, 0);
    read_frame(own(1), ack, rb);
    chk("R1 read after reset", rb, 8'h00);

    for (int it = 0; it < 40; it++) begin
      case ($urandom % 4)
        0, 1: begin
          d  = 8'($urandom);
          op = (($urandom % 5) == 0) ? 8'h80 : {2'b00, 6'($urandom)};
          write_frame(own(1), op, d, acks);
          model_write(op, d);
          chk("R3 write acks", acks, 3'b111);
          chk(op[7] ? "R8 refresh to fuse" : "R3 wiper from data", wiper, m_wiper);
        end
        2: begin
          read_frame(own(1), ack, rb);
          chk("R4 read ack", ack, 1);
          chk("R4 read byte", rb, {m_status, m_wiper});
        end
        default: begin
          do a = 7'($urandom); while (a == own(1));
          write_frame(a, 8'h00, 8'($urandom), acks);
          chk("R2 foreign address nack", acks, 3'b000);
          chk("R2 foreign address no effect", wiper, m_wiper);
        end
      endcase
    end

    write_frame(own(1), 8'h00, 8'hEA, acks);
    model_write(8'h00, 8'hEA);
    write_frame(own(1), 8'h80, 8'h15, acks);
    chk("R8 refresh before burn gives 0", wiper, 0);
    model_write(8'h80, 8'h15);

    bus_start;
    send_byte({own(1), 1'b0}, ack);
    send_byte(8'h00, ack);
    send_byte(8'h1B, ack);
    chk("R11 data byte acked", ack, 1);
    send_byte(8'h07, ack);
    chk("R11 trailing byte nack", ack, 0);
    bus_stop;
    model_write(8'h00, 8'h1B);
    chk("R11 wiper keeps data byte", wiper, m_wiper);

    sel = 1'b0;
    write_frame(own(1), 8'h00, 8'h33, acks);
    chk("R2 select pin low rejects S=1", acks, 3'b000);
    write_frame(own(0), 8'h00, 8'h33, acks);
    model_write(8'h00, 8'h33);
    chk("R2 select pin low accepts S=0", acks, 3'b111);
    chk("R2 write via S=0", wiper, 6'h33);
    sel = 1'b1;

    bus_start;
    send_byte({own(1), 1'b1}, ack);
    recv_byte(1'b1, rb);
    recv_byte(1'b0, rb2);
    bus_stop;
    chk("R4 first of repeated read", rb, {2'b00, 6'h33});
    chk("R4 second of repeated read", rb2, {2'b00, 6'h33});

    write_frame(own(1), 8'h40, 8'hE5, acks);
    chk("R5 burn frame acked", acks, 3'b111);
    chk("R5 burn loads wiper", wiper, 6'h25);
    read_frame(own(1), ack, rb);
    chk("R5 no ack while burning", ack, 0);
    repeat (BURN + 100) @(negedge clk);
    m_wiper = 6'h25; m_fuse = 6'h25; m_locked = 1; m_status = 2'b01;
    read_frame(own(1), ack, rb);
    chk("R7 status after clean burn", rb, {2'b01, 6'h25});
    write_frame(own(1), 8'h00, 8'h11, acks);
    chk("R6 write after lock acked", acks, 3'b111);
    chk("R6 write after lock ignored", wiper, 6'h25);
    write_frame(own(1), 8'h40, 8'h0A, acks);
    chk("R9 second burn acked", acks, 3'b111);
    read_frame(own(1), ack, rb);
    chk("R9 second burn no effect", rb, {2'b01, 6'h25});
    write_frame(own(1), 8'h80, 8'h00, acks);
    chk("R8 refresh after lock", wiper, 6'h25);

    do_reset;
    chk("R1 wiper after second reset", wiper, 0);
    write_frame(own(1), 8'h40, 8'h0C, acks);
    chk("R5 second burn frame acked", acks, 3'b111);
    repeat (50) @(negedge clk);
    fault = 1'b1;
    repeat (3) @(negedge clk);
    fault = 1'b0;
    repeat (BURN + 100) @(negedge clk);
    read_frame(own(1), ack, rb);
    chk("R7 status after faulty burn", rb, {2'b11, 6'h0C});
    write_frame(own(1), 8'h00, 8'h3F, acks);
    chk("R6 write after failed lock ignored", wiper, 6'h0C);

    chk("R10 pull changed while SCL high", r10_viol, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule